// File: doc/BRIEF.md
# Programmable Down-Count Event Timer

This block counts down a 56-bit value at the rate of an external tick strobe and flags an event when the value runs out. Software sets it up with two register writes: first the lower 32 bits of the count, then a control word that holds the upper 24 bits, a run bit, a periodic bit and a commit strobe. The control write with the commit strobe set moves the full 56-bit value into the counter and into a reload store in a single step.

When the count expires, a sticky pending flag is set. In periodic mode the counter takes the stored value again and keeps running. In single mode it stays at zero. The interrupt line is the pending flag gated by a mask bit. The mask bit is changed only through a write-one-to-set address and a write-one-to-clear address, and the pending flag is cleared by writing one to an acknowledge address. A tick arrives for one clock cycle at a time, for instance once per 2 MHz period. Counts of 2 or more are the intended range.

Top module: `evtmr_top`

## Requirements
- R1: After reset every readable register returns 0, the counter is idle and irqOut is low.
- R2: The low-load register at byte offset 0x000 reads back the last word written. The control register at 0x004 reads back bits [23:0] (upper count bits), bit 24 (run) and bit 28 (periodic). The commit bit 30 and all other bits read as 0.
- R3: A control write with bit 30 set loads {control[23:0], low-load} into the counter and into the reload store. A write to the low-load register alone leaves the running count unchanged.
- R4: While the run bit is 1, each clock cycle with tickEn high lowers the count by one. Expiry happens on the tick that takes the count from 1 to 0, so a loaded value N expires on the Nth tick.
- R5: With the periodic bit 0, the counter stays at 0 after expiry and no further expiry happens without a new load.
- R6: With the periodic bit 1, the counter takes the reload value at expiry, and expiries repeat every N ticks.
- R7: Writing 0 to the control register clears the run bit, and ticks then have no effect on the count.
- R8: Writing 1 to bit 0 at 0x02C sets the mask bit, and writing 1 to bit 0 at 0x030 clears it. Writing 0 to either address has no effect. The mask bit reads back at bit 0 of both addresses.
- R9: irqOut is high exactly when the pending flag and the mask bit are both 1.
- R10: Expiry sets the pending flag, which reads at bit 0 of 0x034. Writing 1 to bit 0 at 0x034 clears it, and writing 0 does not. If an expiry happens in the same cycle as the acknowledge, the flag stays set.
- R11: A control write with run set and bit 30 clear resumes counting from the held count without loading.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrite | input | 1 | Register write strobe for the current cycle |
| regAddr | input | ADDR_W | Byte offset used for both write and read |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for regAddr (combinational) |
| tickEn | input | 1 | One-cycle count strobe |
| irqOut | output | 1 | Masked interrupt request |

## Verification
Single-mode loads are swept over a range of small counts. For each count the pending flag is checked one tick before and exactly at the expected expiry, which exposes off-by-one errors in the decrement and expiry logic. Periodic loads over several counts and three periods each separate a correct reload from a single fire or a wrong reload value. A load that differs only in the upper control field confirms that those bits reach the counter. Pause-and-resume and a low-word rewrite in mid-count show that only the commit strobe loads the counter. The mask and acknowledge addresses are tried with both 0 and 1 data, across all pending and mask combinations, and with an acknowledge that lands on an expiry cycle.

// File: rtl/evtmr_pkg.sv
package evtmr_pkg;
  localparam int CNT_W  = 56;
  localparam int DATA_W = 32;
  localparam int LO_W   = DATA_W;
  localparam int HI_W   = CNT_W - LO_W;

  localparam logic [7:0] OFF_LOAD_LO = 8'h00;
  localparam logic [7:0] OFF_CTRL    = 8'h04;
  localparam logic [7:0] OFF_MSET    = 8'h2C;
  localparam logic [7:0] OFF_MCLR    = 8'h30;
  localparam logic [7:0] OFF_ACK     = 8'h34;

  localparam int RUN_BIT = 24;
  localparam int RPT_BIT = 28;
  localparam int LD_BIT  = 30;

  typedef struct packed {
    logic             loadStb;
    logic [CNT_W-1:0] loadVal;
    logic             runEn;
    logic             rptEn;
  } cntCtl_t;
endpackage

// File: rtl/evtmr_regs.sv
module evtmr_regs
  import evtmr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              expire,
  output cntCtl_t           ctl,
  output logic              maskState,
  output logic              pendState,
  output logic              irqOut
);
  logic [LO_W-1:0] loLoad;
  logic [HI_W-1:0] hiLoad;
  logic runEn, rptEn, maskEn, pending;
  logic wrLo, wrCtrl, wrMset, wrMclr, wrAck;
  logic unusedWdata;

  assign unusedWdata = ^{regWdata[31], regWdata[29], regWdata[27:25]};

  always_comb begin
    wrLo   = regWrite && (regAddr == ADDR_W'(OFF_LOAD_LO));
    wrCtrl = regWrite && (regAddr == ADDR_W'(OFF_CTRL));
    wrMset = regWrite && (regAddr == ADDR_W'(OFF_MSET));
    wrMclr = regWrite && (regAddr == ADDR_W'(OFF_MCLR));
    wrAck  = regWrite && (regAddr == ADDR_W'(OFF_ACK));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loLoad  <= '0;
      hiLoad  <= '0;
      runEn   <= 1'b0;
      rptEn   <= 1'b0;
      maskEn  <= 1'b0;
      pending <= 1'b0;
    end else begin
      if (wrLo) loLoad <= regWdata[LO_W-1:0];
      if (wrCtrl) begin
        hiLoad <= regWdata[HI_W-1:0];
        runEn  <= regWdata[RUN_BIT];
        rptEn  <= regWdata[RPT_BIT];
      end
      if (wrMset && regWdata[0])      maskEn <= 1'b1;
      else if (wrMclr && regWdata[0]) maskEn <= 1'b0;
      if (expire)                     pending <= 1'b1;
      else if (wrAck && regWdata[0])  pending <= 1'b0;
    end
  end

  always_comb begin
    ctl.loadStb = wrCtrl && regWdata[LD_BIT];
    ctl.loadVal = {regWdata[HI_W-1:0], loLoad};
    ctl.runEn   = runEn;
    ctl.rptEn   = rptEn;
  end

  always_comb begin
    regRdata = '0;
    if (regAddr == ADDR_W'(OFF_LOAD_LO)) begin
      regRdata = loLoad;
    end else if (regAddr == ADDR_W'(OFF_CTRL)) begin
      regRdata[HI_W-1:0] = hiLoad;
      regRdata[RUN_BIT]  = runEn;
      regRdata[RPT_BIT]  = rptEn;
    end else if (regAddr == ADDR_W'(OFF_MSET) || regAddr == ADDR_W'(OFF_MCLR)) begin
      regRdata[0] = maskEn;
    end else if (regAddr == ADDR_W'(OFF_ACK)) begin
      regRdata[0] = pending;
    end
  end

  assign maskState = maskEn;
  assign pendState = pending;
  assign irqOut    = pending & maskEn;
endmodule

// File: rtl/evtmr_count.sv
module evtmr_count
  import evtmr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  cntCtl_t          ctl,
  output logic             expire,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] reloadVal
);
  logic atOne, stepOk;

  always_comb begin
    stepOk = tickEn && ctl.runEn && !ctl.loadStb && (count != '0);
    atOne  = (count == CNT_W'(1));
    expire = stepOk && atOne;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count     <= '0;
      reloadVal <= '0;
    end else if (ctl.loadStb) begin
      count     <= ctl.loadVal;
      reloadVal <= ctl.loadVal;
    end else if (stepOk) begin
      if (atOne) count <= ctl.rptEn ? reloadVal : '0;
      else       count <= count - CNT_W'(1);
    end
  end
endmodule

// File: rtl/evtmr_top.sv
module evtmr_top
  import evtmr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic              tickEn,
  output logic              irqOut
);
  cntCtl_t          ctl;
  logic             expire;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] reloadVal;
  logic             maskState;
  logic             pendState;

  evtmr_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rstN(rstN), .regWrite(regWrite), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .expire(expire), .ctl(ctl),
    .maskState(maskState), .pendState(pendState), .irqOut(irqOut)
  );

  evtmr_count u_count (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .ctl(ctl),
    .expire(expire), .count(count), .reloadVal(reloadVal)
  );
endmodule

// File: rtl/evtmr_checker.sv
module evtmr_checker
  import evtmr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrite,
  input logic [ADDR_W-1:0] regAddr,
  input logic [31:0]       regWdata,
  input logic              tickEn,
  input cntCtl_t           ctl,
  input logic              expire,
  input logic [CNT_W-1:0]  count,
  input logic [CNT_W-1:0]  reloadVal,
  input logic              maskState,
  input logic              pendState,
  input logic              irqOut
);
  p_load_r3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadStb |=> (count == $past(ctl.loadVal)) && (reloadVal == $past(ctl.loadVal)));

  p_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.loadStb && tickEn && ctl.runEn && count > CNT_W'(1)) |=> count == $past(count) - CNT_W'(1));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.loadStb && !(tickEn && ctl.runEn)) |=> $stable(count));

  p_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    (expire && !ctl.rptEn) |=> count == '0);

  p_reload_r6: assert property (@(posedge clk) disable iff (!rstN)
    (expire && ctl.rptEn) |=> count == $past(reloadVal));

  p_pend_r10: assert property (@(posedge clk) disable iff (!rstN)
    expire |=> pendState);

  p_ack_r10: assert property (@(posedge clk) disable iff (!rstN)
    (regWrite && regAddr == ADDR_W'(OFF_ACK) && regWdata[0] && !expire) |=> !pendState);

  p_mset_r8: assert property (@(posedge clk) disable iff (!rstN)
    (regWrite && regAddr == ADDR_W'(OFF_MSET) && regWdata[0]) |=> maskState);

  p_mclr_r8: assert property (@(posedge clk) disable iff (!rstN)
    (regWrite && regAddr == ADDR_W'(OFF_MCLR) && regWdata[0]) |=> !maskState);

  p_irq_rise_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> (maskState && pendState));
endmodule

bind evtmr_top evtmr_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .regWrite(regWrite), .regAddr(regAddr),
  .regWdata(regWdata), .tickEn(tickEn), .ctl(ctl), .expire(expire),
  .count(count), .reloadVal(reloadVal), .maskState(maskState),
  .pendState(pendState), .irqOut(irqOut)
);

// File: tb/evtmr_top_bench.sv
module evtmr_top_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrite = 1'b0;
  logic [7:0]  regAddr = 8'h00;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        tickEn = 1'b0;
  logic        irqOut;
  int errCnt = 0;
  int chkCnt = 0;
  logic [31:0] rd;

  localparam logic [7:0] A_LO = 8'h00, A_CT = 8'h04, A_MS = 8'h2C, A_MC = 8'h30, A_AK = 8'h34;
  localparam logic [31:0] C_LD = 32'h4000_0000, C_RUN = 32'h0100_0000, C_RPT = 32'h1000_0000;

  always #4 clk = ~clk;

  evtmr_top u_evtmr_top (
    .clk(clk), .rstN(rstN), .regWrite(regWrite), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .tickEn(tickEn), .irqOut(irqOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    chkCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d, input logic t);
    @(negedge clk);
    regWrite = 1'b1; regAddr = a; regWdata = d; tickEn = t;
    @(negedge clk);
    regWrite = 1'b0; tickEn = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tickEn = 1'b1;
    repeat (n) @(negedge clk);
    tickEn = 1'b0;
  endtask

  task automatic readReg(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    regWrite = 1'b0; regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic expectPend(input string req, input logic e);
    readReg(A_AK, rd);
    chk(req, rd, {31'b0, e});
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errCnt++;
    chkCnt++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    readReg(A_LO, rd); chk("R1 lo", rd, 0);
    readReg(A_CT, rd); chk("R1 ctrl", rd, 0);
    readReg(A_MS, rd); chk("R1 mask", rd, 0);
    readReg(A_AK, rd); chk("R1 pend", rd, 0);
    chk("R1 irq", {31'b0, irqOut}, 0);

    // R2 readback
    busWrite(A_LO, 32'hA5A5_1234, 1'b0);
    readReg(A_LO, rd); chk("R2 lo", rd, 32'hA5A5_1234);
    busWrite(A_CT, 32'hFFFF_FFFF, 1'b0);
    readReg(A_CT, rd); chk("R2 ctrl", rd, 32'h11FF_FFFF);
    busWrite(A_CT, 32'h0, 1'b0);
    readReg(A_CT, rd); chk("R7 ctrl zero", rd, 0);

    // R4/R5 single-mode sweep
    busWrite(A_MS, 32'h1, 1'b0);
    for (int n = 2; n <= 7; n++) begin
      busWrite(A_LO, n, 1'b0);
      busWrite(A_CT, C_LD | C_RUN, 1'b0);
      ticks(n - 1);
      expectPend("R4 before expiry", 1'b0);
      ticks(1);
      expectPend("R4 at expiry", 1'b1);
      chk("R9 irq on", {31'b0, irqOut}, 1);
      busWrite(A_AK, 32'h1, 1'b0);
      ticks(2 * n);
      expectPend("R5 no refire", 1'b0);
    end

    // R6 periodic sweep
    for (int n = 2; n <= 5; n++) begin
      busWrite(A_LO, n, 1'b0);
      busWrite(A_CT, C_LD | C_RUN | C_RPT, 1'b0);
      for (int p = 0; p < 3; p++) begin
        ticks(n - 1);
        expectPend("R6 before period end", 1'b0);
        ticks(1);
        expectPend("R6 period end", 1'b1);
        busWrite(A_AK, 32'h1, 1'b0);
      end
    end
    busWrite(A_CT, 32'h0, 1'b0);

    // R3 upper bits reach counter
    busWrite(A_LO, 32'd2, 1'b0);
    busWrite(A_CT, C_LD | C_RUN | 32'h1, 1'b0);
    ticks(5);
    expectPend("R3 upper bits", 1'b0);

    // R3 low write alone does not load
    busWrite(A_LO, 32'd4, 1'b0);
    busWrite(A_CT, C_LD | C_RUN, 1'b0);
    ticks(2);
    busWrite(A_LO, 32'd100, 1'b0);
    ticks(1);
    expectPend("R3 low write no load", 1'b0);
    ticks(1);
    expectPend("R3 count kept", 1'b1);
    busWrite(A_AK, 32'h1, 1'b0);

    // R7 stop and R11 resume
    busWrite(A_LO, 32'd5, 1'b0);
    busWrite(A_CT, C_LD | C_RUN, 1'b0);
    ticks(2);
    busWrite(A_CT, 32'h0, 1'b0);
    ticks(10);
    expectPend("R7 stopped", 1'b0);
    busWrite(A_CT, C_RUN, 1'b0);
    ticks(2);
    expectPend("R11 resume early", 1'b0);
    ticks(1);
    expectPend("R11 resume expiry", 1'b1);

    // R8/R9 mask handling with pending=1
    busWrite(A_MC, 32'h1, 1'b0);
    readReg(A_MS, rd); chk("R8 mask cleared", rd, 0);
    chk("R9 masked", {31'b0, irqOut}, 0);
    busWrite(A_MS, 32'h0, 1'b0);
    readReg(A_MC, rd); chk("R8 zero set ignored", rd, 0);
    chk("R9 still masked", {31'b0, irqOut}, 0);
    busWrite(A_MS, 32'h1, 1'b0);
    readReg(A_MS, rd); chk("R8 mask set", rd, 1);
    chk("R9 unmasked", {31'b0, irqOut}, 1);
    busWrite(A_MC, 32'h0, 1'b0);
    readReg(A_MS, rd); chk("R8 zero clear ignored", rd, 1);
    busWrite(A_AK, 32'h0, 1'b0);
    expectPend("R10 zero ack ignored", 1'b1);
    busWrite(A_AK, 32'h1, 1'b0);
    expectPend("R10 ack clears", 1'b0);
    chk("R9 no pending", {31'b0, irqOut}, 0);

    // R10 expiry beats acknowledge
    busWrite(A_LO, 32'd2, 1'b0);
    busWrite(A_CT, C_LD | C_RUN | C_RPT, 1'b0);
    ticks(2);
    expectPend("R10 first expiry", 1'b1);
    ticks(1);
    busWrite(A_AK, 32'h1, 1'b1);
    expectPend("R10 expiry wins", 1'b1);
    busWrite(A_AK, 32'h1, 1'b0);
    expectPend("R10 later ack", 1'b0);
    busWrite(A_CT, 32'h0, 1'b0);

    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end
endmodule